// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Table

This block sits in a shared memory controller. It tracks the pending load-linked / store-conditional reservations of every requester in one associative table. Each entry holds a reservation address and an authentication key that the table allocates itself. All requesters that reserve the same address share that key. Entries carry no requester identity, so the key alone keeps one LL/SC round on an address apart from the next round on the same address.

A load-linked request returns the key held for its address, or allocates a fresh key from a running counter and records it. A store-conditional request succeeds only when its address and key both match a live entry, and that entry is then consumed. An ordinary write to a reserved address cancels the reservation. The block moves no data. It only reports whether a load-linked request hit an existing reservation or allocated a new one, so the memory path can act on that.

Top module: `rsv_table`

## Requirements
- R1: After synchronous reset, every entry is invalid, `rsp_valid` is 0, and the first key allocated is 1.
- R2: Each request with `req_valid` high gets exactly one response with `rsp_valid` high, on the next clock cycle. No response appears in a cycle that follows a cycle without a request. Requests may arrive on back-to-back cycles.
- R3: A load-linked request (`req_op` = 2'b00) whose address has no valid entry allocates an entry. It records the address and the current counter key, and responds with `rsp_ok`=1, `rsp_hit`=0 and `rsp_key` equal to that key.
- R4: A load-linked request whose address has a valid entry responds with `rsp_ok`=1, `rsp_hit`=1 and the stored key. It allocates nothing and leaves the key counter unchanged.
- R5: A store-conditional request (`req_op` = 2'b01) whose address and key both match a valid entry responds with `rsp_ok`=1 and invalidates that entry. A repeat of the same store-conditional then fails.
- R6: A store-conditional request with no matching address, or with a different key, responds with `rsp_ok`=0 and leaves the table unchanged. Store-conditional and write responses carry `rsp_key`=0 and `rsp_hit`=0.
- R7: The key counter increases by one on each allocation, so an address reserved again after being consumed receives a different key.
- R8: A new allocation uses the lowest-numbered invalid entry. When all 32 entries are valid, it evicts the entry named by a round-robin pointer. The pointer starts at entry 0 and advances by one per eviction. A store-conditional to an evicted reservation fails.
- R9: A write request (`req_op` = 2'b10) to an address with a valid entry invalidates that entry. A write to an unreserved address has no effect. A write responds with `rsp_ok`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 00 load-linked, 01 store-conditional, 10 write, 11 no operation |
| req_addr | input | 32 | Request address |
| req_key | input | 32 | Key presented by a store-conditional |
| rsp_valid | output | 1 | Response present |
| rsp_ok | output | 1 | Load-linked served, or store-conditional succeeded |
| rsp_hit | output | 1 | Load-linked found an existing reservation |
| rsp_key | output | 32 | Key returned to a load-linked requester |

## Verification
Repeated load-linked requests to one address separate the hit path from allocation. Store-conditionals with a wrong key and with an unknown address are then followed by a hit to the same address, which shows the failures changed nothing. A matching store-conditional issued twice, followed by a new load-linked request, separates consumption from key reuse. A write to a reserved address is contrasted with a write to an unreserved one. Finally, a burst of 40 distinct addresses overflows the 32 entries, and store-conditionals across all of them separate the evicted reservations, chosen in round-robin order, from the survivors.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  typedef enum logic [1:0] {
    OP_LL  = 2'b00,
    OP_SC  = 2'b01,
    OP_WR  = 2'b10,
    OP_NOP = 2'b11
  } rsv_op_e;
endpackage

// File: rtl/rsv_match.sv
// Parallel compare of a request against every entry.
module rsv_match #(
  parameter int ENTRIES = 32,
  parameter int ADDR_W  = 32,
  parameter int KEY_W   = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [ADDR_W-1:0] addr_tab_i [ENTRIES],
  input  logic [KEY_W-1:0]  key_tab_i  [ENTRIES],
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [KEY_W-1:0]  key_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  hit_idx_o,
  output logic              key_eq_o
);
  logic [ENTRIES-1:0] addr_hit;
  logic [ENTRIES-1:0] key_eq;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign addr_hit[g] = valid_i[g] && (addr_tab_i[g] == addr_i);
    assign key_eq[g]   = (key_tab_i[g] == key_i);
  end

  always_comb begin
    hit_idx_o = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (addr_hit[i]) hit_idx_o = IDX_W'(i);
  end

  assign hit_o    = |addr_hit;
  assign key_eq_o = key_eq[hit_idx_o];

  // An address never has two live entries (R4: hit instead of re-allocate)
  p_unique_addr_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(addr_hit));
endmodule

// File: rtl/rsv_keygen.sv
// Running key source, advanced once per allocation.
module rsv_keygen #(
  parameter int KEY_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bump_i,
  output logic [KEY_W-1:0] key_o
);
  logic [KEY_W-1:0] key_q;

  always_ff @(posedge clk) begin
    if (rst)         key_q <= KEY_W'(1);
    else if (bump_i) key_q <= key_q + KEY_W'(1);
  end

  assign key_o = key_q;

  p_key_step_r7: assert property (@(posedge clk) disable iff (rst)
    bump_i |=> (key_q == $past(key_q) + KEY_W'(1)));
  p_key_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !bump_i |=> $stable(key_q));
endmodule

// File: rtl/rsv_victim.sv
// Slot choice for a new reservation: lowest free entry, else round-robin.
module rsv_victim #(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic               take_i,
  output logic [IDX_W-1:0]   slot_o
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             full;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!valid_i[i]) free_idx = IDX_W'(i);
  end

  assign full   = &valid_i;
  assign slot_o = full ? rr_q : free_idx;

  always_ff @(posedge clk) begin
    if (rst) rr_q <= '0;
    else if (take_i && full)
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + IDX_W'(1);
  end

  p_rr_advance_r8: assert property (@(posedge clk) disable iff (rst)
    (take_i && full) |=> (rr_q == (($past(rr_q) == IDX_W'(ENTRIES - 1)) ?
                                   '0 : $past(rr_q) + IDX_W'(1))));
  p_rr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !(take_i && full) |=> $stable(rr_q));
endmodule

// File: rtl/rsv_table.sv
// LL/SC reservation table top: request decode, entry storage, response register.
module rsv_table #(
  parameter int ENTRIES = 32,
  parameter int ADDR_W  = 32,
  parameter int KEY_W   = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [KEY_W-1:0]  req_key,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic              rsp_hit,
  output logic [KEY_W-1:0]  rsp_key
);
  import rsv_pkg::*;

  logic [ENTRIES-1:0] valid_q;
  logic [ADDR_W-1:0]  addr_q [ENTRIES];
  logic [KEY_W-1:0]   key_q  [ENTRIES];

  rsv_op_e          op;
  logic             hit, key_eq;
  logic [IDX_W-1:0] hit_idx, slot;
  logic [KEY_W-1:0] new_key;
  logic             is_ll, is_sc, is_wr;
  logic             ll_alloc, sc_ok, drop;

  assign op    = rsv_op_e'(req_op);
  assign is_ll = req_valid && (op == OP_LL);
  assign is_sc = req_valid && (op == OP_SC);
  assign is_wr = req_valid && (op == OP_WR);

  rsv_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .KEY_W(KEY_W)) i_match (
    .clk(clk), .rst(rst), .valid_i(valid_q), .addr_tab_i(addr_q),
    .key_tab_i(key_q), .addr_i(req_addr), .key_i(req_key),
    .hit_o(hit), .hit_idx_o(hit_idx), .key_eq_o(key_eq));

  assign ll_alloc = is_ll && !hit;
  assign sc_ok    = is_sc && hit && key_eq;
  assign drop     = sc_ok || (is_wr && hit);

  rsv_keygen #(.KEY_W(KEY_W)) i_keygen (
    .clk(clk), .rst(rst), .bump_i(ll_alloc), .key_o(new_key));

  rsv_victim #(.ENTRIES(ENTRIES)) i_victim (
    .clk(clk), .rst(rst), .valid_i(valid_q), .take_i(ll_alloc), .slot_o(slot));

  // Valid bits need reset and parallel read; address/key storage has no reset.
  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else if (ll_alloc) valid_q[slot] <= 1'b1;
    else if (drop) valid_q[hit_idx] <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (ll_alloc) begin
      addr_q[slot] <= req_addr;
      key_q[slot]  <= new_key;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_key   <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_ok    <= is_ll || sc_ok;
      rsp_hit   <= is_ll && hit;
      rsp_key   <= !is_ll ? '0 : (hit ? key_q[hit_idx] : new_key);
    end
  end

  p_rsp_next_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  p_rsp_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  p_sc_fail_keeps_r6: assert property (@(posedge clk) disable iff (rst)
    (is_sc && !sc_ok) |=> ($stable(valid_q) && !rsp_ok));
  p_sc_ok_clears_r5: assert property (@(posedge clk) disable iff (rst)
    sc_ok |=> (rsp_ok && !valid_q[$past(hit_idx)]));
  p_wr_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (is_wr && hit) |=> !valid_q[$past(hit_idx)]);
  p_alloc_sets_r3: assert property (@(posedge clk) disable iff (rst)
    ll_alloc |=> (valid_q[$past(slot)] && !rsp_hit && rsp_key == $past(new_key)));
endmodule

// File: tb/test_rsv_table.sv
module test_rsv_table;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'b11;
  logic [31:0] req_addr = '0;
  logic [31:0] req_key = '0;
  logic        rsp_valid, rsp_ok, rsp_hit;
  logic [31:0] rsp_key;

  always #10 clk = ~clk;  // 50 MHz

  rsv_table i_rsv_table (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_key(req_key), .rsp_valid(rsp_valid),
    .rsp_ok(rsp_ok), .rsp_hit(rsp_hit), .rsp_key(rsp_key));

  typedef struct {
    logic        ok;
    logic        hit;
    logic [31:0] key;
    int          cyc;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails  = 0;
  int   cyc    = 0;

  // Behavioural model of the requirements
  logic        m_valid [N];
  logic [31:0] m_addr  [N];
  logic [31:0] m_key   [N];
  logic [31:0] m_next = 32'd1;
  int          m_rr = 0;
  logic [31:0] last_key;
  logic [31:0] fill_key [40];

  always @(posedge clk) cyc <= cyc + 1;

  initial for (int i = 0; i < N; i++) m_valid[i] = 1'b0;

  task automatic send(input logic [1:0] op, input logic [31:0] a,
                      input logic [31:0] k, input string tag);
    exp_t e;
    int   m = -1;
    int   s = -1;
    for (int i = 0; i < N; i++) if (m_valid[i] && m_addr[i] == a) m = i;
    e.ok = 1'b0; e.hit = 1'b0; e.key = '0; e.tag = tag;
    if (op == 2'b00) begin
      e.ok = 1'b1;
      if (m >= 0) begin
        e.hit = 1'b1; e.key = m_key[m];
      end else begin
        for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) s = i;
        if (s < 0) begin s = m_rr; m_rr = (m_rr + 1) % N; end
        m_valid[s] = 1'b1; m_addr[s] = a; m_key[s] = m_next;
        e.key = m_next; m_next = m_next + 1;
      end
    end else if (op == 2'b01) begin
      if (m >= 0 && m_key[m] == k) begin e.ok = 1'b1; m_valid[m] = 1'b0; end
    end else if (op == 2'b10) begin
      if (m >= 0) m_valid[m] = 1'b0;
    end
    last_key = e.key;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_key = k;
    e.cyc = cyc;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 1'b0; req_op = 2'b11;
    repeat (n - 1) @(negedge clk);
  endtask

  // Monitor: compare each response against the scoreboard
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R2: response with no request pending (act valid=1 exp valid=0)");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (cyc != e.cyc + 1) begin
          fails++;
          $display("FAIL R2 %s: latency act %0d exp 1", e.tag, cyc - e.cyc);
        end else if (rsp_ok !== e.ok || rsp_hit !== e.hit || rsp_key !== e.key) begin
          fails++;
          $display("FAIL %s: act ok=%0b hit=%0b key=%0h exp ok=%0b hit=%0b key=%0h",
                   e.tag, rsp_ok, rsp_hit, rsp_key, e.ok, e.hit, e.key);
        end
      end
    end
  end

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: act running exp finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      fails++; $display("FAIL R1: reset rsp_valid act %0b exp 0", rsp_valid);
    end
    rst = 1'b0;
    @(negedge clk);

    send(2'b00, 32'h100, 0, "R1 R3 first LL allocates key 1");
    send(2'b00, 32'h100, 0, "R4 LL hit returns stored key");
    send(2'b00, 32'h200, 0, "R3 LL second address");
    send(2'b01, 32'h100, 32'd2, "R6 SC wrong key fails");
    send(2'b01, 32'h300, 32'd1, "R6 SC unknown address fails");
    send(2'b00, 32'h100, 0, "R6 table unchanged after failed SC");
    send(2'b01, 32'h100, 32'd1, "R5 SC matching succeeds");
    send(2'b01, 32'h100, 32'd1, "R5 repeated SC fails");
    send(2'b00, 32'h100, 0, "R7 reused address gets new key");
    idle(2);
    send(2'b10, 32'h200, 0, "R9 write to reserved address");
    send(2'b01, 32'h200, 32'd2, "R9 SC after write fails");
    send(2'b10, 32'h400, 0, "R9 write to unreserved address");
    send(2'b00, 32'h100, 0, "R9 other reservation kept");
    for (int j = 0; j < 40; j++) begin
      send(2'b00, 32'h1000 + 32'(j * 4), 0, "R8 fill and evict");
      fill_key[j] = last_key;
    end
    for (int j = 0; j < 40; j++)
      send(2'b01, 32'h1000 + 32'(j * 4), fill_key[j], "R8 SC after eviction");
    send(2'b01, 32'h100, 32'd3, "R8 early entry evicted");
    idle(4);
    checks++;
    if (exp_q.size() != 0) begin
      fails++; $display("FAIL R2: missing responses act %0d exp 0", exp_q.size());
    end
    finish_run();
  end
endmodule